// File: doc/BRIEF.md
# Event Counter Bank with Chaining

This block holds four 32-bit event counters that software uses to profile a processor or a system. Every clock cycle it receives a vector of 128 event pulses. Each counter has its own local control register, which picks one of those pulses and says under which conditions it is counted. The conditions are the processor's process mark bit and an external monitor-event input. A global control register freezes or starts all four counters at once.

One reserved event code makes a counter count the wrap-arounds of its upper neighbour instead of a pulse. Two counters then behave as one 64-bit count. Every wrap from all ones to zero leaves a sticky flag in a status register. An enable bit per counter routes that flag to the interrupt output. A further global bit can freeze the whole bank automatically on an enabled wrap.

There are two register ports:
- The supervisor port reads and writes every register.
- The user port sees the same register map, read-only. Its write strobe is ignored.

Software clears the counters, programs the local controls, and then writes zero to the global control to start counting.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset the following values hold: every counter and local control reads 0, the global control reads 0x1 (frozen), the status reads 0, and irq_o is low.
- R2: The register map has word addresses 0 to 3 for counters 0 to 3, 4 to 7 for local controls 0 to 3, 8 for global control and 9 for status. Supervisor reads are combinational, and supervisor writes take effect at the next clock edge.
- R3: The user port returns the same data as the supervisor port for the same address. A user write changes no register.
- R4: A counter increments by exactly one in a cycle only when all of the following hold: its selected event bit is high, the bank is not frozen, and its conditions hold. The local control layout is: event code in bits 6:0, count-when-mark-0 in bit 7, count-when-mark-1 in bit 8, external gate in bit 9, and overflow interrupt enable in bit 10.
- R5: Global control bit 0 is the freeze bit. While it is 1, no counter changes except through supervisor writes. Writing 0 to the global control starts all counters in the same cycle.
- R6: A counter counts only when the mark input is 1 and bit 8 is set, or when the mark input is 0 and bit 7 is set.
- R7: When bit 9 is set, a counter counts only while the monitor-event input is high.
- R8: Event codes 0 to 63 may be counted on any counter. Codes 64 to 127, apart from 83, belong to the counter whose number equals code bits 1:0. On any other counter they count nothing.
- R9: Event code 83 on counter n makes it increment exactly in the cycles when counter n+1 wraps, regardless of its condition bits. On counter 3, code 83 counts nothing.
- R10: A wrap of counter n from 0xFFFFFFFF to 0 sets status bit n. The bit stays set until a supervisor write to the status register with a 1 in bit n. Writing 0 leaves it set.
- R11: irq_o is high exactly when some status bit n is set while bit 10 of local control n is set.
- R12: When global control bit 1 is set, a wrap on a counter whose bit 10 is set also sets the freeze bit at the same clock edge.
- R13: A supervisor write to a counter in a cycle where it would increment loads the written value and drops that increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 128 | Per-cycle event pulses, indexed by event code |
| mon_evt_i | input | 1 | External monitor-event gate |
| mark_i | input | 1 | Process mark bit |
| sv_we | input | 1 | Supervisor write strobe |
| sv_addr | input | 4 | Supervisor word address |
| sv_wdata | input | 32 | Supervisor write data |
| sv_rdata | output | 32 | Supervisor read data |
| usr_we | input | 1 | User write strobe (ignored) |
| usr_addr | input | 4 | User word address |
| usr_wdata | input | 32 | User write data (ignored) |
| usr_rdata | output | 32 | User read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions that bound a counter step to zero or one take for granted that the supervisor port is the only path that can load a counter. For that reason, those assertions are disabled in cycles with a supervisor write. The user-port assertions assume the user strobe can be high together with any address and data. The stimulus deliberately drives user writes with data that differs from the current register contents. Events, the mark bit and the gate input are changed only between clock edges, and each is held for a known number of edges. This lets the bench compute every expected count from the pulse lengths.

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int NCNT = 4,
  parameter int CW   = 32,
  parameter int EW   = 7,
  parameter int AW   = 4,
  localparam int NEV = 1 << EW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           mon_evt_i,
  input  logic           mark_i,
  input  logic           sv_we,
  input  logic [AW-1:0]  sv_addr,
  input  logic [CW-1:0]  sv_wdata,
  output logic [CW-1:0]  sv_rdata,
  input  logic           usr_we,
  input  logic [AW-1:0]  usr_addr,
  input  logic [CW-1:0]  usr_wdata,
  output logic [CW-1:0]  usr_rdata,
  output logic           irq_o
);
  localparam int LW        = EW + 4;
  localparam int CIW       = $clog2(NCNT);
  localparam int SPEC_BASE = NEV / 2;
  localparam int CHAIN     = 83;
  localparam int B_M0      = EW;
  localparam int B_M1      = EW + 1;
  localparam int B_XG      = EW + 2;
  localparam int B_IE      = EW + 3;
  localparam int A_GCTL    = 2 * NCNT;
  localparam int A_GSTAT   = 2 * NCNT + 1;

  logic [CW-1:0]   cnt_q [NCNT];
  logic [LW-1:0]   lcl_q [NCNT];
  logic            frz_q, fov_q;
  logic [NCNT-1:0] ovf_q, inc, wrap, cnt_wr, ie;
  logic            fov_trip, gctl_wr, gstat_wr;

  assign gctl_wr  = sv_we && sv_addr == AW'(A_GCTL);
  assign gstat_wr = sv_we && sv_addr == AW'(A_GSTAT);
  assign fov_trip = fov_q && |(wrap & ie);
  assign irq_o    = |(ovf_q & ie);

  for (genvar g = 0; g < NCNT; g++) begin : g_ie
    assign ie[g] = lcl_q[g][B_IE];
  end

  always_comb begin
    logic          cy, hit, m_ok, x_ok;
    logic [EW-1:0] ev;
    cy = 1'b0;
    for (int i = NCNT - 1; i >= 0; i--) begin
      ev   = lcl_q[i][EW-1:0];
      m_ok = (mark_i && lcl_q[i][B_M1]) || (!mark_i && lcl_q[i][B_M0]);
      x_ok = !lcl_q[i][B_XG] || mon_evt_i;
      if (ev == EW'(CHAIN))
        hit = cy;
      else if (int'(ev) >= SPEC_BASE)
        hit = (ev[CIW-1:0] == CIW'(i)) && evt_i[ev] && m_ok && x_ok;
      else
        hit = evt_i[ev] && m_ok && x_ok;
      cnt_wr[i] = sv_we && sv_addr == AW'(i);
      inc[i]    = hit && !frz_q && !cnt_wr[i];
      wrap[i]   = inc[i] && (&cnt_q[i]);
      cy        = wrap[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) begin
        cnt_q[i] <= '0;
        lcl_q[i] <= '0;
      end
      frz_q <= 1'b1;
      fov_q <= 1'b0;
      ovf_q <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (cnt_wr[i])    cnt_q[i] <= sv_wdata;
        else if (inc[i])  cnt_q[i] <= cnt_q[i] + CW'(1);
        if (sv_we && sv_addr == AW'(NCNT + i)) lcl_q[i] <= sv_wdata[LW-1:0];
      end
      if (gctl_wr) begin
        frz_q <= sv_wdata[0] || fov_trip;
        fov_q <= sv_wdata[1];
      end else if (fov_trip) begin
        frz_q <= 1'b1;
      end
      ovf_q <= (ovf_q & ~(gstat_wr ? sv_wdata[NCNT-1:0] : '0)) | wrap;
    end
  end

  function automatic logic [CW-1:0] rd_mux(input logic [AW-1:0] a);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (a == AW'(i))        r = cnt_q[i];
      if (a == AW'(NCNT + i)) r = CW'(lcl_q[i]);
    end
    if (a == AW'(A_GCTL))  r = CW'({fov_q, frz_q});
    if (a == AW'(A_GSTAT)) r = CW'(ovf_q);
    return r;
  endfunction

  always_comb sv_rdata  = rd_mux(sv_addr);
  always_comb usr_rdata = rd_mux(usr_addr);

  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr[g] |=> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + CW'(1)));
    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !sv_we) |=> cnt_q[g] == $past(cnt_q[g]));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[g] && !(gstat_wr && sv_wdata[g])) |=> ovf_q[g]);
    assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[g] |=> cnt_q[g] == $past(sv_wdata));
    assert_user_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_we && !sv_we) |=> lcl_q[g] == $past(lcl_q[g]));
    assert_user_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_we && !sv_we && frz_q && usr_addr == AW'(g) && usr_wdata != cnt_q[g])
        |=> cnt_q[g] != $past(usr_wdata));
  end

  assert_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_addr == sv_addr) |-> usr_rdata == sv_rdata);
  assert_fov_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fov_trip |=> frz_q);
  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |ovf_q);
endmodule

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt = '0;
  logic         mon = 1'b0, mark = 1'b0;
  logic         sv_we = 1'b0, usr_we = 1'b0;
  logic [3:0]   sv_addr = '0, usr_addr = '0;
  logic [31:0]  sv_wdata = '0, usr_wdata = '0;
  logic [31:0]  sv_rdata, usr_rdata;
  logic         irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  evt_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mon_evt_i(mon), .mark_i(mark),
    .sv_we(sv_we), .sv_addr(sv_addr), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata),
    .usr_we(usr_we), .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.kind == 0) ? sv_rdata : (it.kind == 1) ? usr_rdata : {31'd0, irq};
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    if (kind == 1) usr_addr = a; else sv_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sv_we = 1'b1; sv_addr = a; sv_wdata = d;
    @(posedge clk); #1;
    sv_we = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    @(posedge clk); #1;
    evt[idx] = 1'b1;
    repeat (n) @(posedge clk);
    #1 evt[idx] = 1'b0;
  endtask

  function automatic logic [31:0] lctl(input int ev, input bit m0, input bit m1, input bit xg, input bit ie);
    return 32'(ev) | (32'(m0) << 7) | (32'(m1) << 8) | (32'(xg) << 9) | (32'(ie) << 10);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 8; i++) chk(0, 4'(i), 32'd0, "R1 reset register");
    chk(0, 4'd8, 32'h1, "R1 reset gctl frozen");
    chk(0, 4'd9, 32'h0, "R1 reset status");
    chk(2, 4'd0, 32'h0, "R1 reset irq");

    wr(4'd0, 32'd5);
    chk(0, 4'd0, 32'd5, "R2 supervisor write/read");
    chk(1, 4'd0, 32'd5, "R3 user mirror read");

    @(posedge clk); #1;
    usr_we = 1'b1; usr_addr = 4'd1; usr_wdata = 32'hDEAD;
    @(posedge clk); #1 usr_addr = 4'd4; usr_wdata = 32'h3FF;
    @(posedge clk); #1 usr_we = 1'b0;
    chk(0, 4'd1, 32'd0, "R3 user write to counter ignored");
    chk(0, 4'd4, 32'd0, "R3 user write to control ignored");

    wr(4'd5, lctl(2, 1, 1, 0, 0));
    chk(0, 4'd5, lctl(2, 1, 1, 0, 0), "R2 local control readback");
    pulse(2, 3);
    chk(0, 4'd1, 32'd0, "R5 frozen after reset");
    wr(4'd8, 32'd0);
    pulse(2, 10);
    chk(0, 4'd1, 32'd10, "R4 counts event pulses");
    chk(1, 4'd1, 32'd10, "R3 user sees count");

    wr(4'd6, lctl(5, 0, 1, 0, 0));
    mark = 1'b0; pulse(5, 4);
    chk(0, 4'd2, 32'd0, "R6 mark 0 blocked");
    mark = 1'b1; pulse(5, 3);
    chk(0, 4'd2, 32'd3, "R6 mark 1 counted");

    wr(4'd7, lctl(6, 1, 1, 1, 0));
    mon = 1'b0; pulse(6, 4);
    chk(0, 4'd3, 32'd0, "R7 gate low blocked");
    mon = 1'b1; pulse(6, 2);
    chk(0, 4'd3, 32'd2, "R7 gate high counted");

    wr(4'd7, lctl(66, 1, 1, 0, 0));
    pulse(66, 5);
    chk(0, 4'd3, 32'd2, "R8 foreign specific event ignored");
    wr(4'd6, lctl(66, 1, 1, 0, 0));
    pulse(66, 5);
    chk(0, 4'd2, 32'd8, "R8 owner specific event counted");

    wr(4'd8, 32'd1);
    pulse(2, 4);
    chk(0, 4'd1, 32'd10, "R5 freeze holds count");
    wr(4'd8, 32'd0);

    wr(4'd0, 32'd0);
    wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd4, 32'd83);
    wr(4'd5, lctl(2, 1, 1, 0, 1));
    pulse(2, 3);
    chk(0, 4'd1, 32'd1, "R9 lower half wrapped");
    chk(0, 4'd0, 32'd1, "R9 upper half took carry");
    chk(0, 4'd9, 32'd2, "R10 status flag set");
    chk(2, 4'd0, 32'd1, "R11 irq raised");

    wr(4'd9, 32'd0);
    chk(0, 4'd9, 32'd2, "R10 zero write keeps flag");
    wr(4'd9, 32'd2);
    chk(0, 4'd9, 32'd0, "R10 write one clears flag");
    chk(2, 4'd0, 32'd0, "R11 irq dropped");

    @(posedge clk); #1;
    evt[2] = 1'b1; sv_we = 1'b1; sv_addr = 4'd1; sv_wdata = 32'd100;
    @(posedge clk); #1;
    sv_we = 1'b0; evt[2] = 1'b0;
    chk(0, 4'd1, 32'd100, "R13 write beats increment");

    wr(4'd8, 32'd2);
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd7, lctl(6, 1, 1, 0, 1));
    pulse(6, 1);
    chk(0, 4'd8, 32'd3, "R12 freeze set by overflow");
    chk(0, 4'd3, 32'd0, "R12 counter wrapped");
    chk(0, 4'd9, 32'd8, "R10 flag of counter 3");
    pulse(6, 3);
    chk(0, 4'd3, 32'd0, "R12 bank stays frozen");
    chk(2, 4'd0, 32'd1, "R11 irq from counter 3");

    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule